// File: doc/BRIEF.md
# Parallel Port Control Register

This block is the host-visible control register of a PC-style parallel printer port. It answers at offset 2 of the port's register window. A simple register bus carries a chip select, a 3-bit offset, read and write strobes, and 8-bit write and read data. Six stored bits drive the active-low printer handshake outputs, select the direction of the data pins, and gate the port interrupt.

The interrupt comes from the printer's acknowledge input, which is asynchronous. It passes through a synchronizer and a rising-edge detector. The result is a registered interrupt level. Reading the status register at offset 1 clears that level, and so does dropping the enable bit.

A mode input chooses the port mode. Compatibility (printer) mode always drives the data pins out. Extended mode lets the stored direction bit turn the data pins around.

Top module: `lpt_ctl_reg`

## Requirements
- R1: After reset all six stored bits are 0. The pins then read strobe_n=1, autofd_n=1, slctin_n=1, init_n=0, data_dir_in=0 and irq=0.
- R2: A write with cs=1, wr=1 and addr=2 stores wdata[5:0] at that rising clock edge. A write to any other offset, or a write with cs=0, leaves the stored bits unchanged.
- R3: A read with cs=1, rd=1 and addr=2 returns {2'b00, stored[5:0]} on rdata in the same cycle. Bits 7:6 always read 0, whatever value was written to them. A read of any other offset returns 0.
- R4: The strobe_n pin is the inverse of bit 0. The autofd_n pin is the inverse of bit 1. The slctin_n pin is the inverse of bit 3.
- R5: The init_n pin follows bit 2 without inversion.
- R6: data_dir_in (1 = data pins are inputs) equals bit 5 when ext_mode=1. It is always 0 when ext_mode=0.
- R7: With bit 4 set, a 0-to-1 change on ack_n raises irq at the third rising clock edge after the change.
- R8: With bit 4 clear, irq stays 0 whatever ack_n does. Writing bit 4 to 0 drops irq by the second rising edge after the write edge.
- R9: A read with cs=1, rd=1 and addr=1 clears irq at that clock edge. If a new qualifying edge arrives in the same cycle, the set wins.
- R10: One rising edge of ack_n gives exactly one interrupt event. If ack_n is held high after a clear, irq is not raised again. The synchronizer resets to the idle-high state, so releasing reset with ack_n high raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cs | input | 1 | Chip select for the port's register window |
| addr | input | 3 | Register offset within the window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ext_mode | input | 1 | 1 = extended mode, 0 = compatibility (printer) mode |
| ack_n | input | 1 | Asynchronous acknowledge from the printer |
| strobe_n | output | 1 | Active-low strobe pin |
| autofd_n | output | 1 | Active-low auto line-feed pin |
| init_n | output | 1 | Active-low initialise pin |
| slctin_n | output | 1 | Active-low printer-select pin |
| data_dir_in | output | 1 | 1 = data pins set as inputs |
| irq | output | 1 | Port interrupt level |

## Verification
Each result is due in a fixed cycle:
- The register-driven pins change at the write edge itself.
- rdata is combinational within the read cycle.
- irq rises at the third edge after an ack_n rise, which counts two synchronizer flops and the interrupt register.
- irq falls at the status-read edge, or at the second edge after the enable is cleared.

The bench drives inputs at the falling clock edge and counts falling edges up to the cycle each result is due. It checks both the cycle before the interrupt is due and the cycle it is due, so an extra or a missing register stage is reported.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  // Bit positions of the stored control field
  localparam int unsigned CTL_W     = 6;
  localparam int unsigned B_STROBE  = 0;
  localparam int unsigned B_AUTOFD  = 1;
  localparam int unsigned B_INIT    = 2;
  localparam int unsigned B_SLCTIN  = 3;
  localparam int unsigned B_IEN     = 4;
  localparam int unsigned B_DIR     = 5;

  typedef struct packed {
    logic dir_in;
    logic irq_en;
    logic select;
    logic init;
    logic autofeed;
    logic strobe;
  } ctl_bits_t;
endpackage

// File: rtl/lpt_ctl_store.sv
module lpt_ctl_store
  import lpt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [CTL_W-1:0]  wbits,
  output ctl_bits_t         ctl_q,
  output logic [DATA_W-1:0] rdata
);
  ctl_bits_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_sel) ctl_d = ctl_bits_t'(wbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_sel) rdata[CTL_W-1:0] = ctl_q;
  end

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rdata[DATA_W-1:CTL_W] == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(ctl_q));
endmodule

// File: rtl/lpt_ack_sync.sv
module lpt_ack_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_rise
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb chain_d = {chain_q[CHAIN_W-2:0], ack_n};

  // Reset to the idle-high level so no edge appears after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign ack_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !ack_rise);
endmodule

// File: rtl/lpt_irq_gen.sv
module lpt_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic ack_rise,
  input  logic stat_rd,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (!irq_en)       irq_d = 1'b0;
    else if (ack_rise) irq_d = 1'b1;
    else if (stat_rd)  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ack_rise) |=> irq_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q);

  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ack_rise) |=> !irq_q);
endmodule

// File: rtl/lpt_ctl_reg.sv
module lpt_ctl_reg
  import lpt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CTL_OFFSET  = 2,
  parameter int unsigned STAT_OFFSET = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_mode,
  input  logic              ack_n,
  output logic              strobe_n,
  output logic              autofd_n,
  output logic              init_n,
  output logic              slctin_n,
  output logic              data_dir_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_OFFSET);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFSET);

  logic      ctl_wr;
  logic      ctl_rd;
  logic      stat_rd;
  logic      ack_rise;
  ctl_bits_t ctl_q;

  assign ctl_wr  = cs && wr && (addr == CTL_A);
  assign ctl_rd  = cs && rd && (addr == CTL_A);
  assign stat_rd = cs && rd && (addr == STAT_A);

  lpt_ctl_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sel(ctl_wr),
    .rd_sel(ctl_rd),
    .wbits (wdata[CTL_W-1:0]),
    .ctl_q (ctl_q),
    .rdata (rdata)
  );

  lpt_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_n   (ack_n),
    .ack_rise(ack_rise)
  );

  lpt_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (ctl_q.irq_en),
    .ack_rise(ack_rise),
    .stat_rd (stat_rd),
    .irq_q   (irq)
  );

  // Pin polarity: three inverted, initialise passes straight through
  assign strobe_n    = ~ctl_q.strobe;
  assign autofd_n    = ~ctl_q.autofeed;
  assign slctin_n    = ~ctl_q.select;
  assign init_n      =  ctl_q.init;
  assign data_dir_in = ext_mode & ctl_q.dir_in;

  // R4
  strobe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (strobe_n == !$past(wdata[B_STROBE])) &&
               (slctin_n == !$past(wdata[B_SLCTIN])));

  // R5
  init_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (init_n == $past(wdata[B_INIT])));

  // R6
  printer_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !data_dir_in);

  // R3
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wdata[DATA_W-1:CTL_W] != '0)) |=>
      (ctl_q == ctl_bits_t'($past(wdata[CTL_W-1:0]))));
endmodule

// File: tb/lpt_ctl_reg_tb.sv
module lpt_ctl_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_mode = 1'b0;
  logic       ack_n = 1'b1;
  logic       strobe_n, autofd_n, init_n, slctin_n, data_dir_in, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpt_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .ext_mode(ext_mode), .ack_n(ack_n),
    .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
    .slctin_n(slctin_n), .data_dir_in(data_dir_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {2'b00, data_dir_in, irq, slctin_n, init_n, autofd_n, strobe_n};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pins", pins(), 8'b0000_1011);
    bus_read(3'd2, d);
    chk("R1 readback", d, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    bus_write(3'd2, 8'h25, 1'b1);
    bus_read(3'd2, d);
    chk("R2 store 25", d, 8'h25);
    bus_write(3'd2, 8'h0A, 1'b1);
    bus_read(3'd2, d);
    chk("R2 store 0A", d, 8'h0A);
    bus_write(3'd2, 8'hFF, 1'b1);
    bus_read(3'd2, d);
    chk("R3 upper bits read zero", d, 8'h3F);
    bus_write(3'd2, 8'hC0, 1'b1);
    bus_read(3'd2, d);
    chk("R3 upper bits ignored", d, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    bus_write(3'd2, 8'h09, 1'b1);
    bus_write(3'd3, 8'h36, 1'b1);
    bus_read(3'd2, d);
    chk("R2 other offset ignored", d, 8'h09);
    bus_write(3'd2, 8'h36, 1'b0);
    bus_read(3'd2, d);
    chk("R2 no cs ignored", d, 8'h09);
    bus_read(3'd0, d);
    chk("R3 other offset reads 0", d, 8'h00);
  endtask

  task automatic t_pins();
    bus_write(3'd2, 8'h01, 1'b1);
    chk("R4 strobe", {5'b0, slctin_n, autofd_n, strobe_n}, 8'b0000_0110);
    bus_write(3'd2, 8'h0A, 1'b1);
    chk("R4 autofd slctin", {5'b0, slctin_n, autofd_n, strobe_n}, 8'b0000_0001);
    chk("R5 init low", {7'b0, init_n}, 8'h00);
    bus_write(3'd2, 8'h04, 1'b1);
    chk("R5 init high", {7'b0, init_n}, 8'h01);
  endtask

  task automatic t_dir();
    ext_mode = 1'b0;
    bus_write(3'd2, 8'h20, 1'b1);
    chk("R6 printer mode out", {7'b0, data_dir_in}, 8'h00);
    ext_mode = 1'b1;
    #1 chk("R6 ext mode in", {7'b0, data_dir_in}, 8'h01);
    bus_write(3'd2, 8'h00, 1'b1);
    chk("R6 ext mode out", {7'b0, data_dir_in}, 8'h00);
    ext_mode = 1'b0;
  endtask

  task automatic ack_pulse_rise_check(input string tag, input logic exp3);
    @(negedge clk); ack_n = 1'b0;
    repeat (4) @(negedge clk);
    ack_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " not yet"}, {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk({tag, " due"}, {7'b0, irq}, {7'b0, exp3});
  endtask

  task automatic t_irq_disabled();
    bus_write(3'd2, 8'h00, 1'b1);
    ack_pulse_rise_check("R8 disabled", 1'b0);
  endtask

  task automatic t_irq_enabled();
    bus_write(3'd2, 8'h10, 1'b1);
    ack_pulse_rise_check("R7 enabled", 1'b1);
  endtask

  task automatic t_status_clear();
    logic [7:0] d;
    bus_read(3'd1, d);
    chk("R9 status read clears", {7'b0, irq}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R10 no re-raise", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ien_clear();
    ack_pulse_rise_check("R7 second edge", 1'b1);
    bus_write(3'd2, 8'h00, 1'b1);
    @(negedge clk);
    chk("R8 enable clear drops", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (4) @(negedge clk);
    chk("R10 no event after reset", {7'b0, irq}, 8'h00);
    t_write_read();
    t_ignored();
    t_pins();
    t_dir();
    t_irq_disabled();
    t_irq_enabled();
    t_status_clear();
    t_ien_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule